// File: doc/BRIEF.md
# Multi-port packet egress transmit controller

This block sends packet fragments from per-port internal buffers onto a byte-wide egress bus that is shared by up to eight logical ports. It also scans the attached device's per-port readiness. A poll address walks a programmable sequence, and the device answers one cycle later with a single ready bit. The block uses these answers to decide which ports may transmit. Flow control runs in one of two modes. In level mode a ready port keeps sending. In credit mode each fresh ready answer permits exactly one fragment.

Each fragment is one address cycle that names the port, followed by a fixed number of data bytes read from the buffer. The last byte carries an end-of-packet flag when the buffer reports that the fragment closes a packet. Two optional idle cycles can be placed before each address cycle, and two more after each end-of-packet byte. Each port has an enable bit and a bit-reversal bit. A test register injects one corrupted parity bit on either the next address cycle or the next data cycle of a chosen port. The test bit then clears itself.

Configuration comes through a small write-only register port. The buffer memory lies outside the block. It returns `buf_data` in the same cycle for the port and byte index that the block presents.

Top module: `port_egress_tx`

## Requirements
- R1: `poll_addr` resets to 0. It steps by one each cycle and returns to 0 in the cycle after it shows LEN−1, where LEN is register 0 bits [5:0] (reset value 15). A LEN of 0 or 1 holds `poll_addr` at 0.
- R2: In level mode (register 1 bit 0 = 0), `poll_stat` sampled one cycle after a port's address was shown becomes that port's ready state. A port whose ready state is 0 starts no new fragment.
- R3: In credit mode (register 1 bit 0 = 1), a `poll_stat` of 1 for a port grants that port one credit. Each fragment start uses the credit, and a ready answer in the same cycle as the start does not restore it.
- R4: When register 1 bit 1 is 0, a port starts at most one fragment per pass of the poll sequence. Its marker clears in the cycle in which `poll_addr` returns to 0. When the bit is 1, this limit does not apply.
- R5: A port is eligible only if its enable bit (register 3 bit p, reset 0) is set and `buf_avail[p]` is high. A disabled port is never selected.
- R6: From the idle state, the block starts the first eligible port after the last port served, in increasing order with wrap-around. Port 0 is searched first after reset. At least one idle cycle separates fragments.
- R7: A fragment is one cycle with `tx_stx` high and `tx_data` equal to the port number. It is followed by FRAG_BYTES cycles with `tx_dv` and `rd_en` high, where `rd_idx` counts from 0. `tx_eop` is high on the last byte exactly when `buf_eop[p]` was high at selection.
- R8: With register 0 bit 6 set, two idle cycles come before every address cycle.
- R9: With register 0 bit 7 set, two idle cycles follow a byte that carries end-of-packet. A fragment that does not end a packet gets none.
- R10: With register 3 bit 8+p set, port p's data bytes go out bit-reversed (bit 7 to bit 0). Address cycles and other ports are unchanged.
- R11: On address and data cycles `tx_par` makes `{tx_data,tx_par}` hold an odd number of ones. On every other cycle `tx_data` and `tx_par` are 0.
- R12: Register 2 holds the target port in [7:0], the address-error request in bit 8 and the data-error request in bit 9. Each request inverts `tx_par` on exactly one cycle: the next address cycle (bit 8) or the next data cycle (bit 9) of that port. The request then clears itself, and a target that is not a real port never fires.
- R13: During and just after reset, no strobe is high and `tx_data`, `tx_par` and `poll_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select 0..3 |
| cfg_wdata | input | 16 | Register write data |
| poll_addr | output | 6 | Port address being polled |
| poll_stat | input | 1 | Ready answer for the address shown one cycle earlier |
| buf_avail | input | NPORT | Per-port fragment available in buffer |
| buf_eop | input | NPORT | Per-port: pending fragment ends a packet |
| rd_en | output | 1 | Buffer byte read |
| rd_port | output | PORT_W | Port being read |
| rd_idx | output | IDX_W | Byte index within the fragment |
| buf_data | input | 8 | Buffer byte for rd_port/rd_idx, same cycle |
| tx_data | output | 8 | Egress bus: port number or data byte |
| tx_stx | output | 1 | Address cycle strobe |
| tx_dv | output | 1 | Data cycle strobe |
| tx_eop | output | 1 | Last byte of a packet |
| tx_par | output | 1 | Odd parity over tx_data |

## Verification
The hardest case to reach is a one-shot parity error that has to land on a chosen port's address or data cycle. That cycle exists only after the poll answers, the eligibility gating and the round-robin pointer have all brought the fragment around. The bench sets the request while every port streams in level mode. It then counts inverted-parity cycles on the bus and expects exactly one per request, and none for a target with no matching port. The credit mode and the once-per-pass limit depend on the timing between poll answers and fragment starts. A cycle-exact behavioural model follows the poll sequence and the per-port ready, credit and used state, so any drift shows up on the very cycle it happens.

// File: rtl/egx_pkg.sv
package egx_pkg;

   localparam int DATA_W  = 8;
   localparam int PADDR_W = 6;
   localparam int MASK_W  = 8;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PRE  = 3'd1,
      ST_ADDR = 3'd2,
      ST_DATA = 3'd3,
      ST_POST = 3'd4
   } tx_state_t;

   typedef struct packed {
      logic [PADDR_W-1:0] poll_len;
      logic               start_pad;
      logic               end_pad;
      logic               credit_mode;
      logic               multi_burst;
      logic [7:0]         test_port;
      logic               err_addr;
      logic               err_data;
      logic [MASK_W-1:0]  port_en;
      logic [MASK_W-1:0]  port_rev;
   } egx_cfg_t;

endpackage

// File: rtl/egx_cfg.sv
module egx_cfg
   import egx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [1:0]  addr,
   input  logic [15:0] wdata,
   input  logic        clr_err_addr,
   input  logic        clr_err_data,
   output egx_cfg_t    cfg
);

   localparam logic [PADDR_W-1:0] LEN_RST = PADDR_W'(15);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg             <= '0;
         cfg.poll_len    <= LEN_RST;
      end else begin
         if (clr_err_addr)
            cfg.err_addr <= 1'b0;
         if (clr_err_data)
            cfg.err_data <= 1'b0;
         if (we) begin
            case (addr)
               2'd0: begin
                  cfg.poll_len  <= wdata[PADDR_W-1:0];
                  cfg.start_pad <= wdata[6];
                  cfg.end_pad   <= wdata[7];
               end
               2'd1: begin
                  cfg.credit_mode <= wdata[0];
                  cfg.multi_burst <= wdata[1];
               end
               2'd2: begin
                  cfg.test_port <= wdata[7:0];
                  cfg.err_addr  <= wdata[8];
                  cfg.err_data  <= wdata[9];
               end
               default: begin
                  cfg.port_en  <= wdata[7:0];
                  cfg.port_rev <= wdata[15:8];
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/egx_poll.sv
module egx_poll
   import egx_pkg::*;
#(
   parameter int NPORT  = 4,
   parameter int PORT_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PADDR_W-1:0] poll_len,
   input  logic               poll_stat,
   input  logic               grant_vld,
   input  logic [PORT_W-1:0]  grant_port,
   output logic [PADDR_W-1:0] poll_addr,
   output logic [NPORT-1:0]   ready,
   output logic [NPORT-1:0]   credit,
   output logic [NPORT-1:0]   used
);

   logic [PADDR_W-1:0] idx_q;
   logic [PADDR_W-1:0] prv_q;
   logic               prv_vld_q;
   logic               wrap;

   assign wrap      = ({1'b0, idx_q} + (PADDR_W+1)'(1)) >= {1'b0, poll_len};
   assign poll_addr = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q     <= '0;
         prv_q     <= '0;
         prv_vld_q <= 1'b0;
      end else begin
         idx_q     <= wrap ? '0 : idx_q + PADDR_W'(1);
         prv_q     <= idx_q;
         prv_vld_q <= 1'b1;
      end
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic hit;
      logic taken;
      assign hit   = prv_vld_q && (prv_q == PADDR_W'(p));
      assign taken = grant_vld && (grant_port == PORT_W'(p));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ready[p]  <= 1'b0;
            credit[p] <= 1'b0;
            used[p]   <= 1'b0;
         end else begin
            if (hit)
               ready[p] <= poll_stat;
            if (taken)
               credit[p] <= 1'b0;
            else if (hit && poll_stat)
               credit[p] <= 1'b1;
            if (taken)
               used[p] <= 1'b1;
            else if (wrap)
               used[p] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/egx_arb.sv
module egx_arb #(
   parameter int NPORT  = 4,
   parameter int PORT_W = 2
) (
   input  logic [NPORT-1:0]  elig,
   input  logic [PORT_W-1:0] last,
   output logic              any,
   output logic [PORT_W-1:0] pick
);

   always_comb begin
      any  = 1'b0;
      pick = '0;
      for (int k = 1; k <= NPORT; k++) begin
         int j;
         j = int'(last) + k;
         if (j >= NPORT)
            j = j - NPORT;
         if (!any && elig[j]) begin
            any  = 1'b1;
            pick = PORT_W'(j);
         end
      end
   end

endmodule

// File: rtl/egx_tx.sv
module egx_tx
   import egx_pkg::*;
#(
   parameter int NPORT      = 4,
   parameter int PORT_W     = 2,
   parameter int FRAG_BYTES = 64,
   parameter int IDX_W      = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  egx_cfg_t           cfg,
   input  logic               any,
   input  logic [PORT_W-1:0]  pick,
   input  logic [NPORT-1:0]   buf_eop,
   input  logic [DATA_W-1:0]  buf_data,
   output logic               grant_vld,
   output logic [PORT_W-1:0]  grant_port,
   output logic [PORT_W-1:0]  last_port,
   output logic               rd_en,
   output logic [PORT_W-1:0]  rd_port,
   output logic [IDX_W-1:0]   rd_idx,
   output logic [DATA_W-1:0]  tx_data,
   output logic               tx_stx,
   output logic               tx_dv,
   output logic               tx_eop,
   output logic               tx_par,
   output logic               clr_err_addr,
   output logic               clr_err_data
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAG_BYTES - 1);

   tx_state_t          state_q;
   logic               pad_q;
   logic [IDX_W-1:0]   idx_q;
   logic [PORT_W-1:0]  cur_q;
   logic [PORT_W-1:0]  last_q;
   logic               eop_q;
   logic [DATA_W-1:0]  rev_byte;
   logic [DATA_W-1:0]  data_byte;
   logic               tgt_hit;
   logic               flip;

   assign grant_vld  = (state_q == ST_IDLE) && any;
   assign grant_port = pick;
   assign last_port  = last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pad_q   <= 1'b0;
         idx_q   <= '0;
         cur_q   <= '0;
         last_q  <= PORT_W'(NPORT - 1);
         eop_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (any) begin
               state_q <= cfg.start_pad ? ST_PRE : ST_ADDR;
               cur_q   <= pick;
               last_q  <= pick;
               eop_q   <= buf_eop[pick];
               pad_q   <= 1'b0;
            end
            ST_PRE: begin
               if (pad_q) begin
                  state_q <= ST_ADDR;
                  pad_q   <= 1'b0;
               end else
                  pad_q <= 1'b1;
            end
            ST_ADDR: begin
               state_q <= ST_DATA;
               idx_q   <= '0;
            end
            ST_DATA: begin
               if (idx_q == LAST_IDX) begin
                  state_q <= (eop_q && cfg.end_pad) ? ST_POST : ST_IDLE;
                  pad_q   <= 1'b0;
               end else
                  idx_q <= idx_q + IDX_W'(1);
            end
            ST_POST: begin
               if (pad_q) begin
                  state_q <= ST_IDLE;
                  pad_q   <= 1'b0;
               end else
                  pad_q <= 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_rev
      assign rev_byte[b] = buf_data[DATA_W-1-b];
   end

   assign data_byte = cfg.port_rev[cur_q] ? rev_byte : buf_data;
   assign tgt_hit   = (cfg.test_port == 8'(cur_q));

   assign rd_en   = (state_q == ST_DATA);
   assign rd_port = cur_q;
   assign rd_idx  = idx_q;

   assign tx_stx  = (state_q == ST_ADDR);
   assign tx_dv   = (state_q == ST_DATA);
   assign tx_eop  = tx_dv && eop_q && (idx_q == LAST_IDX);
   assign tx_data = tx_stx ? DATA_W'(cur_q) : (tx_dv ? data_byte : '0);

   assign clr_err_addr = tx_stx && cfg.err_addr && tgt_hit;
   assign clr_err_data = tx_dv  && cfg.err_data && tgt_hit;
   assign flip         = clr_err_addr || clr_err_data;
   assign tx_par       = (tx_stx || tx_dv) ? (~^tx_data) ^ flip : 1'b0;

endmodule

// File: rtl/port_egress_tx.sv
module port_egress_tx
   import egx_pkg::*;
#(
   parameter int NPORT      = 4,
   parameter int FRAG_BYTES = 64,
   localparam int PORT_W    = (NPORT > 1) ? $clog2(NPORT) : 1,
   localparam int IDX_W     = (FRAG_BYTES > 1) ? $clog2(FRAG_BYTES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_addr,
   input  logic [15:0]        cfg_wdata,
   output logic [5:0]         poll_addr,
   input  logic               poll_stat,
   input  logic [NPORT-1:0]   buf_avail,
   input  logic [NPORT-1:0]   buf_eop,
   output logic               rd_en,
   output logic [PORT_W-1:0]  rd_port,
   output logic [IDX_W-1:0]   rd_idx,
   input  logic [7:0]         buf_data,
   output logic [7:0]         tx_data,
   output logic               tx_stx,
   output logic               tx_dv,
   output logic               tx_eop,
   output logic               tx_par
);

   if (NPORT < 2 || NPORT > MASK_W) begin : g_bad_nport
      $error("port_egress_tx: NPORT must be in 2..8");
   end
   if (FRAG_BYTES < 2) begin : g_bad_frag
      $error("port_egress_tx: FRAG_BYTES must be at least 2");
   end

   egx_cfg_t           cfg_q;
   logic               clr_a;
   logic               clr_d;
   logic               grant_vld;
   logic [PORT_W-1:0]  grant_port;
   logic [PORT_W-1:0]  last_port;
   logic [NPORT-1:0]   ready;
   logic [NPORT-1:0]   credit;
   logic [NPORT-1:0]   used;
   logic [NPORT-1:0]   flow_ok;
   logic [NPORT-1:0]   burst_ok;
   logic [NPORT-1:0]   elig;
   logic               any;
   logic [PORT_W-1:0]  pick;

   egx_cfg u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .we           (cfg_we),
      .addr         (cfg_addr),
      .wdata        (cfg_wdata),
      .clr_err_addr (clr_a),
      .clr_err_data (clr_d),
      .cfg          (cfg_q)
   );

   egx_poll #(.NPORT(NPORT), .PORT_W(PORT_W)) u_poll (
      .clk        (clk),
      .rst_n      (rst_n),
      .poll_len   (cfg_q.poll_len),
      .poll_stat  (poll_stat),
      .grant_vld  (grant_vld),
      .grant_port (grant_port),
      .poll_addr  (poll_addr),
      .ready      (ready),
      .credit     (credit),
      .used       (used)
   );

   assign flow_ok  = cfg_q.credit_mode ? credit : ready;
   assign burst_ok = cfg_q.multi_burst ? {NPORT{1'b1}} : ~used;
   assign elig     = cfg_q.port_en[NPORT-1:0] & buf_avail & flow_ok & burst_ok;

   egx_arb #(.NPORT(NPORT), .PORT_W(PORT_W)) u_arb (
      .elig (elig),
      .last (last_port),
      .any  (any),
      .pick (pick)
   );

   egx_tx #(
      .NPORT(NPORT), .PORT_W(PORT_W), .FRAG_BYTES(FRAG_BYTES), .IDX_W(IDX_W)
   ) u_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg          (cfg_q),
      .any          (any),
      .pick         (pick),
      .buf_eop      (buf_eop),
      .buf_data     (buf_data),
      .grant_vld    (grant_vld),
      .grant_port   (grant_port),
      .last_port    (last_port),
      .rd_en        (rd_en),
      .rd_port      (rd_port),
      .rd_idx       (rd_idx),
      .tx_data      (tx_data),
      .tx_stx       (tx_stx),
      .tx_dv        (tx_dv),
      .tx_eop       (tx_eop),
      .tx_par       (tx_par),
      .clr_err_addr (clr_a),
      .clr_err_data (clr_d)
   );

endmodule

// File: rtl/port_egress_tx_chk.sv
module port_egress_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [5:0] poll_addr,
   input logic       rd_en,
   input logic [7:0] tx_data,
   input logic       tx_stx,
   input logic       tx_dv,
   input logic       tx_eop,
   input logic       tx_par
);

   // R1
   poll_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_addr != 6'd0) |-> (poll_addr == $past(poll_addr) + 6'd1));

   // R7
   stx_dv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_stx && tx_dv));

   // R7
   stx_then_dv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_stx |=> tx_dv);

   // R7
   eop_needs_dv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_eop |-> tx_dv);

   // R7
   rd_with_dv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en == tx_dv);

   // R6
   gap_after_frag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_eop |=> !tx_dv);

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_stx || tx_dv) |-> (tx_data == 8'd0 && !tx_par));

endmodule

bind port_egress_tx port_egress_tx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .poll_addr (poll_addr),
   .rd_en     (rd_en),
   .tx_data   (tx_data),
   .tx_stx    (tx_stx),
   .tx_dv     (tx_dv),
   .tx_eop    (tx_eop),
   .tx_par    (tx_par)
);

// File: tb/port_egress_tx_tb.sv
module port_egress_tx_tb;

   localparam int TCLK = 10;
   localparam int NP   = 4;
   localparam int FB   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic [5:0]  poll_addr;
   logic        poll_stat = 1'b0;
   logic [NP-1:0] buf_avail = '0;
   logic [NP-1:0] buf_eop = '0;
   logic        rd_en;
   logic [1:0]  rd_port;
   logic [2:0]  rd_idx;
   logic [7:0]  buf_data;
   logic [7:0]  tx_data;
   logic        tx_stx, tx_dv, tx_eop, tx_par;

   int checks = 0;
   int errors = 0;
   string tag = "R13";
   logic [NP-1:0] stat_vec = '0;
   int a1 = 0;

   function automatic logic [7:0] bdat(int p, int i);
      return 8'(p * 37 + i * 11 + 5);
   endfunction

   function automatic logic [7:0] brev(logic [7:0] v);
      logic [7:0] r;
      for (int b = 0; b < 8; b++) r[b] = v[7-b];
      return r;
   endfunction

   assign buf_data = bdat(int'(rd_port), int'(rd_idx));

   port_egress_tx #(.NPORT(NP), .FRAG_BYTES(FB)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .poll_addr(poll_addr), .poll_stat(poll_stat),
      .buf_avail(buf_avail), .buf_eop(buf_eop), .rd_en(rd_en),
      .rd_port(rd_port), .rd_idx(rd_idx), .buf_data(buf_data),
      .tx_data(tx_data), .tx_stx(tx_stx), .tx_dv(tx_dv), .tx_eop(tx_eop),
      .tx_par(tx_par)
   );

   always #(TCLK/2) clk = ~clk;

   // reference model state
   int m_pidx = 0, m_plen = 15, m_prev = 0, m_pv = 0;
   int m_ready[NP], m_credit[NP], m_used[NP];
   int m_state = 0, m_pad = 0, m_cnt = 0, m_cur = 0, m_last = NP - 1, m_eop = 0;
   int c_spad = 0, c_epad = 0, c_credit = 0, c_multi = 0, c_tport = 0;
   int c_ea = 0, c_ed = 0, c_en = 0, c_rev = 0;

   task automatic model_reset();
      m_pidx = 0; m_plen = 15; m_prev = 0; m_pv = 0;
      for (int p = 0; p < NP; p++) begin
         m_ready[p] = 0; m_credit[p] = 0; m_used[p] = 0;
      end
      m_state = 0; m_pad = 0; m_cnt = 0; m_cur = 0; m_last = NP - 1; m_eop = 0;
      c_spad = 0; c_epad = 0; c_credit = 0; c_multi = 0; c_tport = 0;
      c_ea = 0; c_ed = 0; c_en = 0; c_rev = 0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         int elig[NP];
         int gnt, wrap, st, hit_t;
         for (int p = 0; p < NP; p++)
            elig[p] = ((c_en >> p) & 1) && buf_avail[p] &&
                      (c_credit ? m_credit[p] : m_ready[p]) &&
                      (c_multi || !m_used[p]);
         gnt = -1;
         if (m_state == 0)
            for (int k = 1; k <= NP; k++)
               if (gnt < 0 && elig[(m_last + k) % NP]) gnt = (m_last + k) % NP;
         wrap = (m_pidx + 1 >= m_plen);
         if (m_pv && m_prev < NP) begin
            m_ready[m_prev] = poll_stat;
            if (poll_stat) m_credit[m_prev] = 1;
         end
         if (wrap) for (int p = 0; p < NP; p++) m_used[p] = 0;
         if (gnt >= 0) begin m_credit[gnt] = 0; m_used[gnt] = 1; end
         m_prev = m_pidx; m_pv = 1;
         m_pidx = wrap ? 0 : m_pidx + 1;
         hit_t = (c_tport == m_cur);
         st = m_state;
         if (st == 2 && c_ea && hit_t) c_ea = 0;
         if (st == 3 && c_ed && hit_t) c_ed = 0;
         case (st)
            0: if (gnt >= 0) begin
                  m_state = c_spad ? 1 : 2; m_cur = gnt; m_last = gnt;
                  m_eop = buf_eop[gnt]; m_pad = 0;
               end
            1: if (m_pad) begin m_state = 2; m_pad = 0; end else m_pad = 1;
            2: begin m_state = 3; m_cnt = 0; end
            3: if (m_cnt == FB - 1) begin
                  m_state = (m_eop && c_epad) ? 4 : 0; m_pad = 0;
               end else m_cnt++;
            default: if (m_pad) begin m_state = 0; m_pad = 0; end else m_pad = 1;
         endcase
         if (cfg_we) begin
            case (cfg_addr)
               2'd0: begin m_plen = cfg_wdata[5:0]; c_spad = cfg_wdata[6]; c_epad = cfg_wdata[7]; end
               2'd1: begin c_credit = cfg_wdata[0]; c_multi = cfg_wdata[1]; end
               2'd2: begin c_tport = cfg_wdata[7:0]; c_ea = cfg_wdata[8]; c_ed = cfg_wdata[9]; end
               default: begin c_en = cfg_wdata[7:0]; c_rev = cfg_wdata[15:8]; end
            endcase
         end
      end
   end

   function automatic logic [17:0] model_out();
      logic stx, dv, eop, par;
      logic [7:0] d;
      int flip;
      stx = (m_state == 2); dv = (m_state == 3);
      d = 8'd0; eop = 1'b0; par = 1'b0;
      flip = (c_tport == m_cur) && ((stx && c_ea) || (dv && c_ed));
      if (stx) d = 8'(m_cur);
      if (dv) begin
         d = bdat(m_cur, m_cnt);
         if ((c_rev >> m_cur) & 1) d = brev(d);
         eop = m_eop && (m_cnt == FB - 1);
      end
      if (stx || dv) par = ~(^d) ^ flip[0];
      return {stx, dv, eop, d, par, 6'(m_pidx)};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison and observation counters
   int obs_stx[NP];
   int obs_parerr = 0;
   always @(negedge clk) begin
      logic [17:0] act, exp;
      act = {tx_stx, tx_dv, tx_eop, tx_data, tx_par, poll_addr};
      exp = model_out();
      chk(act == exp, tag, int'(act), int'(exp));
      if (tx_stx && int'(tx_data) < NP) obs_stx[tx_data] = obs_stx[tx_data] + 1;
      if ((tx_stx || tx_dv) && !(^{tx_data, tx_par})) obs_parerr++;
      poll_stat <= (a1 < NP) ? stat_vec[a1] : 1'b0;
      a1 <= int'(poll_addr);
   end

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr_obs();
      for (int p = 0; p < NP; p++) obs_stx[p] = 0;
      obs_parerr = 0;
   endtask

   task automatic finish_up();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R13 watchdog act=running exp=finished");
      finish_up();
   end

   initial begin
      for (int p = 0; p < NP; p++) obs_stx[p] = 0;
      // R13: reset state
      tag = "R13";
      repeat (3) @(negedge clk);
      chk({tx_stx, tx_dv, tx_eop, tx_par} == 4'b0, "R13", int'({tx_stx, tx_dv, tx_eop, tx_par}), 0);
      chk(tx_data == 8'd0 && poll_addr == 6'd0, "R13", int'({tx_data, poll_addr}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!tx_stx && !tx_dv, "R13", int'({tx_stx, tx_dv}), 0);

      // R1: default length then a short one
      tag = "R1";
      run(40);
      wr(2'd0, 16'd5);
      run(20);

      // R6, R7: all ports ready, multi-burst on
      tag = "R6_R7";
      stat_vec = 4'hF; buf_avail = 4'hF; buf_eop = 4'b0101;
      wr(2'd1, 16'h0002);
      wr(2'd3, 16'h000F);
      clr_obs();
      run(200);
      chk(obs_stx[0] > 0 && obs_stx[3] > 0, "R6", obs_stx[3], 1);

      // R8, R9, R10: pads and bit reversal on port 1
      tag = "R8_R9_R10";
      wr(2'd0, 16'h00C5);
      wr(2'd3, 16'h020F);
      run(200);
      wr(2'd0, 16'h0005);
      wr(2'd3, 16'h000F);

      // R2: port 2 not ready in level mode
      tag = "R2";
      stat_vec = 4'b1011;
      run(30);
      clr_obs();
      run(120);
      chk(obs_stx[2] == 0, "R2", obs_stx[2], 0);
      chk(obs_stx[1] > 0, "R2", obs_stx[1], 1);
      stat_vec = 4'hF;

      // R3: credit mode
      tag = "R3";
      wr(2'd1, 16'h0003);
      run(200);
      stat_vec = 4'b0001;
      run(30);
      clr_obs();
      run(100);
      chk(obs_stx[1] == 0, "R3", obs_stx[1], 0);
      stat_vec = 4'hF;

      // R4: one fragment per poll pass
      tag = "R4";
      wr(2'd1, 16'h0000);
      wr(2'd0, 16'd40);
      buf_avail = 4'b0001;
      run(20);
      clr_obs();
      run(80);
      chk(obs_stx[0] <= 2, "R4", obs_stx[0], 2);
      wr(2'd0, 16'd5);
      buf_avail = 4'hF;
      run(100);

      // R5: port 0 disabled
      tag = "R5";
      wr(2'd1, 16'h0002);
      wr(2'd3, 16'h000E);
      run(20);
      clr_obs();
      run(150);
      chk(obs_stx[0] == 0, "R5", obs_stx[0], 0);
      chk(obs_stx[2] > 0, "R5", obs_stx[2], 1);
      wr(2'd3, 16'h000F);

      // R12: parity error injection
      tag = "R12";
      clr_obs();
      wr(2'd2, 16'h0101);
      run(100);
      chk(obs_parerr == 1, "R12", obs_parerr, 1);
      clr_obs();
      wr(2'd2, 16'h0202);
      run(100);
      chk(obs_parerr == 1, "R12", obs_parerr, 1);
      clr_obs();
      wr(2'd2, 16'h0305);
      run(100);
      chk(obs_parerr == 0, "R12", obs_parerr, 0);
      wr(2'd2, 16'h0000);

      // R11: parity across reversed and plain data
      tag = "R11";
      wr(2'd3, 16'h0A0F);
      clr_obs();
      run(150);
      chk(obs_parerr == 0, "R11", obs_parerr, 0);

      // R1: lengths 0 and 63
      tag = "R1";
      wr(2'd0, 16'd0);
      run(20);
      wr(2'd0, 16'd63);
      run(150);

      finish_up();
   end

endmodule